// File: doc/BRIEF.md
# Memory Error Capture Registers

This block keeps a software-visible record of memory ECC events. A correctable-error source and an uncorrectable-error source each present a one-cycle valid pulse together with the full physical address of the failing access and the index of the memory row it hit. The block holds three registers on a simple register bus: an error address pointer, an error status word and an error command word. It also drives a system-error pulse for the error classes that software has enabled.

The pointer register records one failing location to 4 KB granularity and then locks. It stays locked until software clears its pending flags by writing ones to them. The status register records, for each class separately, the row of the first error of that class since its flag was last cleared. Clearing the flags re-arms capture. Writes are single-cycle strobes. Reads are combinational from the selected register.

Top module: `memErrCapture`

## Requirements
- R1: After reset every register reads zero and `sysErr` is low.
- R2: Register select 0 is the address pointer. Bits 31:12 hold bits 31:12 of the logged failing address, and bits 11:2 read zero.
- R3: When the pointer logs an event, pointer bit 0 is set for a correctable event and bit 1 for an uncorrectable event, one cycle after the event pulse.
- R4: While either pointer flag is set, later events change neither the logged address nor the flags.
- R5: Writing 1 to pointer bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged. Once both flags are clear, the next event is logged, including an event in the same cycle as the clearing write.
- R6: Register select 1 is the status word. Bit 0 flags a correctable error and bits 3:1 hold the row of the first one. The row is captured only while bit 0 is clear, and it is kept after the flag is cleared.
- R7: In the status word, bit 4 flags an uncorrectable error and bits 7:5 hold the row of the first one, with the same capture rule as R6. Bits 31:8 read zero.
- R8: Writing 1 to status bit 0 or bit 4 clears that flag alone. Other status bits ignore writes.
- R9: When both classes pulse in the same cycle and the pointer is free, both pointer flags are set and the logged address is the uncorrectable one. Both status classes capture their rows.
- R10: Register select 2 is the command word. Bit 0 enables the system error for correctable events and bit 1 for uncorrectable events. Its other bits read zero, and register select 3 reads zero.
- R11: `sysErr` is high for exactly one cycle, in the cycle after an event newly sets its status flag while that class is enabled by the command value held before that edge. Events that find the flag already set raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sbeValid | input | 1 | Correctable (single-bit) event pulse |
| sbeAddr | input | 32 | Physical address of the correctable event |
| sbeRow | input | 3 | Row index of the correctable event |
| mbeValid | input | 1 | Uncorrectable (multi-bit) event pulse |
| mbeAddr | input | 32 | Physical address of the uncorrectable event |
| mbeRow | input | 3 | Row index of the uncorrectable event |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register |
| sysErr | output | 1 | One-cycle system-error pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 3-bit row indices and a 4 KB address grain. These values put the status word at its full eight-bit layout and place the page field at bits 31:12, so every field position in the requirements is checked directly. A behavioural model runs alongside and is compared on every cycle. Directed sequences cover the corner cases: a locked pointer, clearing and logging in the same cycle, simultaneous classes, and disabled system errors. A long random stream of events and writes then covers the interleavings.

// File: rtl/memErrPkg.sv
package memErrPkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_PTR = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STS = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CMD = 2'd2;

  // class index: 0 = correctable, 1 = uncorrectable
  localparam int CLS_SB = 0;
  localparam int CLS_MB = 1;

  typedef struct packed {
    logic       logPtr;      // pointer takes a new address and flags
    logic       logFromMb;   // address source is the uncorrectable event
    logic [1:0] logFlag;     // flag values loaded on logPtr
    logic [1:0] clrPtr;      // write-one-to-clear on pointer flags
    logic [1:0] capSts;      // status class captures its row
    logic [1:0] clrSts;      // write-one-to-clear on status flags
    logic       cmdWr;       // command word load
    logic       raiseSysErr; // system-error pulse next cycle
  } errStrobes_t;
endpackage

// File: rtl/memErrCtrl.sv
module memErrCtrl
  import memErrPkg::*;
(
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regAddr,
  input  logic [1:0]       ptrClrBits,
  input  logic [1:0]       stsClrBits,
  input  logic             sbeValid,
  input  logic             mbeValid,
  input  logic [1:0]       ptrFlag,
  input  logic [1:0]       stsOcc,
  input  logic [1:0]       cmdEn,
  output errStrobes_t      stb
);
  logic wrPtr, wrSts, wrCmd;
  logic [1:0] evValid;
  logic [1:0] ptrClr;
  logic [1:0] stsClr;
  logic [1:0] capture;
  logic ptrArmed;

  assign wrPtr   = regWrEn && (regAddr == SEL_PTR);
  assign wrSts   = regWrEn && (regAddr == SEL_STS);
  assign wrCmd   = regWrEn && (regAddr == SEL_CMD);
  assign evValid = {mbeValid, sbeValid};

  genvar c;
  generate
    for (c = 0; c < 2; c++) begin : gCls
      assign ptrClr[c]  = wrPtr & ptrClrBits[c];
      assign stsClr[c]  = wrSts & stsClrBits[c];
      // a flag cleared this cycle no longer blocks capture
      assign capture[c] = evValid[c] & ~(stsOcc[c] & ~stsClr[c]);
    end
  endgenerate

  assign ptrArmed = ~|(ptrFlag & ~ptrClr);

  always_comb begin
    stb             = '0;
    stb.logPtr      = ptrArmed & (|evValid);
    stb.logFromMb   = evValid[CLS_MB];
    stb.logFlag     = evValid;
    stb.clrPtr      = ptrClr;
    stb.capSts      = capture;
    stb.clrSts      = stsClr;
    stb.cmdWr       = wrCmd;
    stb.raiseSysErr = |(capture & cmdEn);
  end
endmodule

// File: rtl/memErrRegs.sv
module memErrRegs
  import memErrPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 3,
  parameter int GRAIN  = 12,
  localparam int PAGE_W = ADDR_W - GRAIN,
  localparam int DATA_W = ADDR_W,
  localparam int STS_W  = 2 * (ROW_W + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  errStrobes_t                stb,
  input  logic [PAGE_W-1:0]          sbePage,
  input  logic [PAGE_W-1:0]          mbePage,
  input  logic [ROW_W-1:0]           sbeRow,
  input  logic [ROW_W-1:0]           mbeRow,
  input  logic [1:0]                 cmdData,
  input  logic [SEL_W-1:0]           regAddr,
  output logic [PAGE_W-1:0]          ptrPage,
  output logic [1:0]                 ptrFlag,
  output logic [1:0]                 stsOcc,
  output logic [1:0][ROW_W-1:0]      stsRow,
  output logic [1:0]                 cmdEn,
  output logic                       sysErr,
  output logic [DATA_W-1:0]          regRdData
);
  logic [1:0][ROW_W-1:0] evRow;
  assign evRow = {mbeRow, sbeRow};

  // address pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrPage <= '0;
      ptrFlag <= '0;
    end else if (stb.logPtr) begin
      ptrPage <= stb.logFromMb ? mbePage : sbePage;
      ptrFlag <= stb.logFlag;
    end else begin
      ptrFlag <= ptrFlag & ~stb.clrPtr;
    end
  end

  // per-class status capture
  genvar c;
  generate
    for (c = 0; c < 2; c++) begin : gSts
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stsOcc[c] <= 1'b0;
          stsRow[c] <= '0;
        end else if (stb.capSts[c]) begin
          stsOcc[c] <= 1'b1;
          stsRow[c] <= evRow[c];
        end else if (stb.clrSts[c]) begin
          stsOcc[c] <= 1'b0;
        end
      end
    end
  endgenerate

  // command word and system-error pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdEn  <= '0;
      sysErr <= 1'b0;
    end else begin
      sysErr <= stb.raiseSysErr;
      if (stb.cmdWr) cmdEn <= cmdData;
    end
  end

  // read mux
  logic [DATA_W-1:0] ptrWord, stsWord, cmdWord;
  assign ptrWord = {ptrPage, {(GRAIN-2){1'b0}}, ptrFlag[CLS_MB], ptrFlag[CLS_SB]};
  assign stsWord = {{(DATA_W-STS_W){1'b0}},
                    stsRow[CLS_MB], stsOcc[CLS_MB], stsRow[CLS_SB], stsOcc[CLS_SB]};
  assign cmdWord = {{(DATA_W-2){1'b0}}, cmdEn};

  always_comb begin
    case (regAddr)
      SEL_PTR: regRdData = ptrWord;
      SEL_STS: regRdData = stsWord;
      SEL_CMD: regRdData = cmdWord;
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/memErrCapture.sv
module memErrCapture
  import memErrPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 3,
  parameter int GRAIN  = 12,
  localparam int PAGE_W = ADDR_W - GRAIN,
  localparam int DATA_W = ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sbeValid,
  input  logic [ADDR_W-1:0] sbeAddr,
  input  logic [ROW_W-1:0]  sbeRow,
  input  logic              mbeValid,
  input  logic [ADDR_W-1:0] mbeAddr,
  input  logic [ROW_W-1:0]  mbeRow,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sysErr
);
  errStrobes_t           stb;
  logic [PAGE_W-1:0]     ptrPage;
  logic [1:0]            ptrFlag;
  logic [1:0]            stsOcc;
  logic [1:0][ROW_W-1:0] stsRow;
  logic [1:0]            cmdEn;

  logic unusedBits;
  assign unusedBits = ^{sbeAddr[GRAIN-1:0], mbeAddr[GRAIN-1:0], regWrData};

  memErrCtrl uCtrl (
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .ptrClrBits (regWrData[1:0]),
    .stsClrBits ({regWrData[ROW_W+1], regWrData[0]}),
    .sbeValid   (sbeValid),
    .mbeValid   (mbeValid),
    .ptrFlag    (ptrFlag),
    .stsOcc     (stsOcc),
    .cmdEn      (cmdEn),
    .stb        (stb)
  );

  memErrRegs #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .GRAIN(GRAIN)) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sbePage   (sbeAddr[ADDR_W-1:GRAIN]),
    .mbePage   (mbeAddr[ADDR_W-1:GRAIN]),
    .sbeRow    (sbeRow),
    .mbeRow    (mbeRow),
    .cmdData   (regWrData[1:0]),
    .regAddr   (regAddr),
    .ptrPage   (ptrPage),
    .ptrFlag   (ptrFlag),
    .stsOcc    (stsOcc),
    .stsRow    (stsRow),
    .cmdEn     (cmdEn),
    .sysErr    (sysErr),
    .regRdData (regRdData)
  );
endmodule

// File: rtl/memErrCaptureChk.sv
module memErrCaptureChk
  import memErrPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 3,
  parameter int GRAIN  = 12,
  localparam int PAGE_W = ADDR_W - GRAIN
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sbeValid,
  input logic                  mbeValid,
  input logic [ADDR_W-1:0]     mbeAddr,
  input logic                  regWrEn,
  input logic [SEL_W-1:0]      regAddr,
  input logic [ADDR_W-1:0]     regWrData,
  input logic [ADDR_W-1:0]     regRdData,
  input logic                  sysErr,
  input logic [PAGE_W-1:0]     ptrPage,
  input logic [1:0]            ptrFlag,
  input logic [1:0]            stsOcc,
  input logic [1:0][ROW_W-1:0] stsRow
);
  p_ptr_lock_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|ptrFlag) && !(regWrEn && regAddr == SEL_PTR) |=> $stable(ptrPage) && (|ptrFlag));

  p_sb_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    stsOcc[0] && !(regWrEn && regAddr == SEL_STS && regWrData[0])
    |=> stsOcc[0] && $stable(stsRow[0]));

  p_mb_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    stsOcc[1] && !(regWrEn && regAddr == SEL_STS && regWrData[ROW_W+1])
    |=> stsOcc[1] && $stable(stsRow[1]));

  p_both_classes_r9: assert property (@(posedge clk) disable iff (!rstN)
    sbeValid && mbeValid && (ptrFlag == 2'b00)
    |=> (ptrFlag == 2'b11) && (ptrPage == $past(mbeAddr[ADDR_W-1:GRAIN])));

  p_spare_select_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> (regRdData == '0));

  p_sys_err_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    sysErr |-> $past(sbeValid || mbeValid));
endmodule

bind memErrCapture memErrCaptureChk #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .GRAIN(GRAIN)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .sbeValid  (sbeValid),
  .mbeValid  (mbeValid),
  .mbeAddr   (mbeAddr),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .sysErr    (sysErr),
  .ptrPage   (ptrPage),
  .ptrFlag   (ptrFlag),
  .stsOcc    (stsOcc),
  .stsRow    (stsRow)
);

// File: tb/tb_memErrCapture.sv
module tb_memErrCapture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sbeValid = 1'b0, mbeValid = 1'b0;
  logic [31:0] sbeAddr = '0, mbeAddr = '0;
  logic [2:0]  sbeRow = '0, mbeRow = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sysErr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  string curTag = "R1";

  always #2 clk = ~clk;

  memErrCapture dut (
    .clk(clk), .rstN(rstN),
    .sbeValid(sbeValid), .sbeAddr(sbeAddr), .sbeRow(sbeRow),
    .mbeValid(mbeValid), .mbeAddr(mbeAddr), .mbeRow(mbeRow),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .sysErr(sysErr)
  );

  // behavioural reference model
  logic [19:0] mPage = '0;
  logic        mSb = 0, mMb = 0;
  logic        mOcc[2] = '{0, 0};
  logic [2:0]  mRow[2] = '{0, 0};
  logic [1:0]  mCmd = '0;
  logic        mSys = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPage = '0; mSb = 0; mMb = 0; mCmd = '0; mSys = 0;
      mOcc[0] = 0; mOcc[1] = 0; mRow[0] = '0; mRow[1] = '0;
    end else begin
      bit wrP, wrS, wrC, sbLeft, mbLeft, newSb, newMb, occLeft;
      wrP = regWrEn && regAddr == 2'd0;
      wrS = regWrEn && regAddr == 2'd1;
      wrC = regWrEn && regAddr == 2'd2;
      sbLeft = mSb && !(wrP && regWrData[0]);
      mbLeft = mMb && !(wrP && regWrData[1]);
      if (!sbLeft && !mbLeft && (sbeValid || mbeValid)) begin
        mPage = mbeValid ? mbeAddr[31:12] : sbeAddr[31:12];
        mSb = sbeValid; mMb = mbeValid;
      end else begin
        mSb = sbLeft; mMb = mbLeft;
      end
      newSb = 0; newMb = 0;
      occLeft = mOcc[0] && !(wrS && regWrData[0]);
      if (!occLeft && sbeValid) begin mOcc[0] = 1; mRow[0] = sbeRow; newSb = 1; end
      else mOcc[0] = occLeft;
      occLeft = mOcc[1] && !(wrS && regWrData[4]);
      if (!occLeft && mbeValid) begin mOcc[1] = 1; mRow[1] = mbeRow; newMb = 1; end
      else mOcc[1] = occLeft;
      mSys = (newSb && mCmd[0]) || (newMb && mCmd[1]);
      if (wrC) mCmd = regWrData[1:0];
    end
  end

  function automatic logic [31:0] modelRead(logic [1:0] sel);
    case (sel)
      2'd0: return {mPage, 10'b0, mMb, mSb};
      2'd1: return {24'b0, mRow[1], mOcc[1], mRow[0], mOcc[0]};
      2'd2: return {30'b0, mCmd};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, clock, compare with model at next negedge
  task automatic step(input logic sV, input logic [31:0] sA, input logic [2:0] sR,
                      input logic mV, input logic [31:0] mA, input logic [2:0] mR,
                      input logic w, input logic [1:0] sel, input logic [31:0] d);
    sbeValid = sV; sbeAddr = sA; sbeRow = sR;
    mbeValid = mV; mbeAddr = mA; mbeRow = mR;
    regWrEn = w; regAddr = sel; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    sbeValid = 0; mbeValid = 0; regWrEn = 0;
    check(curTag, regRdData, modelRead(regAddr));
    check(curTag, {31'b0, sysErr}, {31'b0, mSys});
  endtask

  task automatic rd(input logic [1:0] sel);
    step(0, 0, 0, 0, 0, 0, 0, sel, 0);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    step(0, 0, 0, 0, 0, 0, 1, sel, d);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", regRdData, 32'h0);
    check("R1", {31'b0, sysErr}, 32'h0);
    rstN = 1'b1;

    curTag = "R1";
    rd(0); check("R1", regRdData, 32'h0);
    rd(1); check("R1", regRdData, 32'h0);
    rd(2); check("R1", regRdData, 32'h0);

    curTag = "R10";
    wr(2, 32'hFFFF_FFFF); check("R10", regRdData, 32'h3);

    curTag = "R3";
    step(1, 32'h1234_5ABC, 3'd5, 0, 0, 0, 0, 0, 0);
    check("R11", {31'b0, sysErr}, 32'h1);
    check("R2", regRdData, 32'h1234_5001);
    curTag = "R6";
    rd(1);
    check("R6", regRdData, 32'h0B);
    check("R11", {31'b0, sysErr}, 32'h0);

    curTag = "R4";
    step(1, 32'hDEAD_0000, 3'd2, 0, 0, 0, 0, 0, 0);
    check("R4", regRdData, 32'h1234_5001);
    check("R11", {31'b0, sysErr}, 32'h0);

    curTag = "R7";
    step(0, 0, 0, 1, 32'hCAFE_B123, 3'd6, 0, 1, 0);
    check("R7", regRdData, 32'hDB);
    check("R11", {31'b0, sysErr}, 32'h1);
    rd(0); check("R4", regRdData, 32'h1234_5001);

    curTag = "R5";
    wr(0, 32'h0); check("R5", regRdData, 32'h1234_5001);
    wr(0, 32'h1); check("R5", regRdData, 32'h1234_5000);
    step(1, 32'h00AB_C777, 3'd1, 0, 0, 0, 0, 0, 0);
    check("R5", regRdData, 32'h00AB_C001);
    check("R11", {31'b0, sysErr}, 32'h0);
    rd(1); check("R6", regRdData, 32'hDB);

    curTag = "R8";
    wr(1, 32'hFFFF_FFEE); check("R8", regRdData, 32'hDB);
    wr(1, 32'h01); check("R8", regRdData, 32'hDA);
    wr(1, 32'h10); check("R8", regRdData, 32'hCA);

    curTag = "R9";
    wr(2, 32'h0);
    wr(0, 32'h3); check("R5", regRdData, 32'h00AB_C000);
    step(1, 32'h1111_1000, 3'd3, 1, 32'h2222_2000, 3'd4, 0, 0, 0);
    check("R9", regRdData, 32'h2222_2003);
    check("R11", {31'b0, sysErr}, 32'h0);
    rd(1); check("R9", regRdData, 32'h97);
    rd(3); check("R10", regRdData, 32'h0);

    curTag = "R5";
    step(0, 0, 0, 1, 32'h3333_3FFF, 3'd7, 1, 0, 32'h3);
    check("R5", regRdData, 32'h3333_3002);
    rd(1); check("R7", regRdData, 32'h97);

    curTag = "R11";
    wr(2, 32'h2);
    wr(1, 32'h11);
    step(1, 32'h4444_4000, 3'd2, 0, 0, 0, 0, 1, 0);
    check("R11", {31'b0, sysErr}, 32'h0);
    step(0, 0, 0, 1, 32'h5555_5000, 3'd1, 0, 1, 0);
    check("R11", {31'b0, sysErr}, 32'h1);
    check("R7", regRdData, 32'h35);

    curTag = "R5";
    for (int i = 0; i < 2000; i++) begin
      logic sV, mV, w;
      logic [31:0] d;
      sV = ($urandom_range(0, 3) == 0);
      mV = ($urandom_range(0, 4) == 0);
      w  = ($urandom_range(0, 3) == 0);
      d  = $urandom;
      step(sV, $urandom, 3'($urandom), mV, $urandom, 3'($urandom),
           w, 2'($urandom), d);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule